// File: doc/BRIEF.md
# Frame Alignment Measurement Unit

This block measures how far a frame-evaluation signal lags behind the reference frame pulse. A host starts a measurement by raising a start bit. The block waits for the next reference frame edge. Over the following frame it counts the time until the first matching edge of the evaluation signal. At the frame boundary after that, it returns the count together with a completion flag. The count is in half master-clock periods. The block runs on a sampling clock at twice the master-clock rate, so one sampling cycle equals one half period.

Two frame-pulse conventions are supported, chosen by a format select input. In one, falling edges of the frame pulse and of the evaluation signal are compared. In the other, rising edges are compared. The host must hold the start bit low across a whole frame before a rise of the bit is accepted. Returning the bit low clears the completion flag and cancels any measurement in progress.

Top module: `frame_align_meter`

## Requirements
- R1: After reset, `done_o` is 0 and `offset_o` is 0.
- R2: With `fmt_rise_i` = 0, the offset is the number of sampling cycles from the cycle in which `frame_i` falls to the cycle in which `eval_i` falls.
- R3: With `fmt_rise_i` = 1, the offset is the number of sampling cycles from the cycle in which `frame_i` rises to the cycle in which `eval_i` rises.
- R4: Only the first matching evaluation edge in the measured frame is captured. Any later edges in that frame leave the result unchanged.
- R5: An evaluation edge in the same cycle as the reference edge that opens the measured frame gives an offset of 0.
- R6: If no matching evaluation edge occurs in the measured frame, the offset is 4095 (all ones).
- R7: The count saturates at 4095. An evaluation edge that arrives 4095 or more cycles after the reference edge reports 4095.
- R8: `done_o` stays 0 until the second reference edge after an accepted start rise. It goes to 1 in the cycle after that edge is sampled. At that point `offset_o` holds the new result.
- R9: A rise of `start_i` is ignored unless the bit was low across at least two reference frame edges, which is one whole frame. An ignored rise produces no completion, however many frames follow.
- R10: When `start_i` is low, `done_o` is 0 in the next cycle. Dropping `start_i` before completion cancels the measurement.
- R11: `offset_o` changes only when `done_o` rises. It holds the last result through cancelled or ignored measurements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, twice the master-clock rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Reference frame pulse |
| eval_i | input | 1 | Frame-evaluation signal whose delay is measured |
| start_i | input | 1 | Measurement start bit from the host control register |
| fmt_rise_i | input | 1 | 0: compare falling edges, 1: compare rising edges |
| offset_o | output | 12 | Measured offset in half master-clock periods |
| done_o | output | 1 | Completion flag |

## Verification
The bench aims at the edges of the count window. An evaluation edge in the very cycle of the opening reference edge must give 0; a design that starts counting one cycle late would report a shifted value there. A frame with no evaluation edge and a frame longer than 4095 cycles must both report all ones; a wrapping counter would return a small number instead. Two evaluation edges in one frame catch a design that keeps the last edge rather than the first. Dropping the start bit mid-measurement, and a start rise after too short a low phase, catch a design that completes anyway or overwrites the held offset.

// File: rtl/fam_pkg.sv
package fam_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_MEAS = 2'd2,
    ST_DONE = 2'd3
  } fam_state_e;

  // Edge of the selected polarity between two consecutive samples
  function automatic logic edge_seen(input logic prev, input logic cur, input logic rising);
    return rising ? (!prev && cur) : (prev && !cur);
  endfunction
endpackage

// File: rtl/fam_edge.sv
module fam_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic rise_i,
  output logic hit_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  assign hit_o = fam_pkg::edge_seen(prev_q, sig_i, rise_i);
endmodule

// File: rtl/fam_qual.sv
module fam_qual #(
  parameter int QUAL_EDGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ref_hit_i,
  output logic arm_o
);
  localparam int CW = $clog2(QUAL_EDGES + 1);

  logic          start_q;
  logic [CW-1:0] low_edges_q;
  logic          qualified;

  assign qualified = (low_edges_q == CW'(QUAL_EDGES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q     <= 1'b0;
      low_edges_q <= '0;
    end else begin
      start_q <= start_i;
      if (start_i)                     low_edges_q <= '0;
      else if (ref_hit_i && !qualified) low_edges_q <= low_edges_q + 1'b1;
    end
  end

  assign arm_o = start_i && !start_q && qualified;

  // R9: an accepted start must follow a low phase of the start bit
  a_r9_arm_after_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_o |-> !$past(start_i));
endmodule

// File: rtl/fam_count.sv
module fam_count #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ref_hit_i,
  input  logic         eval_hit_i,
  input  logic         win_i,
  input  logic         clr_i,
  output logic [W-1:0] result_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q, elapsed, cap_q;
  logic         cap_vld_q;

  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  assign elapsed = ref_hit_i ? '0 : sat_inc(cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      cap_q     <= '0;
      cap_vld_q <= 1'b0;
    end else begin
      cnt_q <= elapsed;
      if (clr_i) begin
        cap_vld_q <= 1'b0;
      end else if (win_i && eval_hit_i && !cap_vld_q) begin
        cap_vld_q <= 1'b1;
        cap_q     <= elapsed;
      end
    end
  end

  assign result_o = cap_vld_q ? cap_q : CNT_MAX;

  a_r7_count_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !ref_hit_i) |=> cnt_q == CNT_MAX);

  a_r4_first_edge_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_vld_q && !clr_i) |=> (cap_vld_q && $stable(cap_q)));
endmodule

// File: rtl/frame_align_meter.sv
module frame_align_meter #(
  parameter int OFFS_W     = 12,
  parameter int QUAL_EDGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              eval_i,
  input  logic              start_i,
  input  logic              fmt_rise_i,
  output logic [OFFS_W-1:0] offset_o,
  output logic              done_o
);
  import fam_pkg::*;

  localparam int NSIG = 2;

  logic [NSIG-1:0] raw, hits;
  logic            ref_hit, eval_hit, arm, win;
  logic [OFFS_W-1:0] result, offset_q;
  logic            done_q;
  fam_state_e      st_q;

  assign raw = {eval_i, frame_i};

  for (genvar k = 0; k < NSIG; k++) begin : g_edge
    fam_edge u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sig_i (raw[k]),
      .rise_i(fmt_rise_i),
      .hit_o (hits[k])
    );
  end

  assign ref_hit  = hits[0];
  assign eval_hit = hits[1];

  fam_qual #(.QUAL_EDGES(QUAL_EDGES)) u_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .ref_hit_i(ref_hit),
    .arm_o    (arm)
  );

  // Capture window: the measured frame, including its opening edge cycle
  assign win = (st_q == ST_MEAS && !ref_hit) || (st_q == ST_SYNC && ref_hit);

  fam_count #(.W(OFFS_W)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_hit_i (ref_hit),
    .eval_hit_i(eval_hit),
    .win_i     (win),
    .clr_i     (arm),
    .result_o  (result)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      done_q   <= 1'b0;
      offset_q <= '0;
    end else if (!start_i) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (arm)     st_q <= ST_SYNC;
        ST_SYNC: if (ref_hit) st_q <= ST_MEAS;
        ST_MEAS: if (ref_hit) begin
          st_q     <= ST_DONE;
          done_q   <= 1'b1;
          offset_q <= result;
        end
        ST_DONE: st_q <= ST_DONE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign offset_o = offset_q;
  assign done_o   = done_q;

  a_r10_done_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);

  a_r8_done_on_ref_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(ref_hit));

  a_r8_done_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(start_i));

  a_r11_offset_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(offset_o) |-> $rose(done_o));
endmodule

// File: tb/frame_align_meter_tb.sv
module frame_align_meter_tb_top;
  localparam int W = 12;
  localparam int SAT = 4095;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_s = 1'b1, eval_s = 1'b1, start_s = 1'b0, fmt_s = 1'b0;
  logic [W-1:0] offset_w;
  logic done_w;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [W-1:0] last_off = '0;

  always #2.5 clk = ~clk;

  frame_align_meter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame_s), .eval_i(eval_s),
    .start_i(start_s), .fmt_rise_i(fmt_s), .offset_o(offset_w), .done_o(done_w)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cycles);
      finish_run();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic idle_lvl();
    return !fmt_s;
  endfunction

  // Reference model: first edge index within the frame, saturated
  function automatic int expect_off(input int len, input int d1, input int d2);
    int first = -1;
    if (d1 >= 0 && d1 < len) first = d1;
    if (d2 >= 0 && d2 < len && (first < 0 || d2 < first)) first = d2;
    if (first < 0) return SAT;
    return (first > SAT) ? SAT : first;
  endfunction

  task automatic drive(input logic fpv, input logic fev);
    frame_s = fpv;
    eval_s  = fev;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(idle_lvl(), idle_lvl());
  endtask

  task automatic frame(input int len, input int d1, input int d2);
    for (int c = 0; c < len; c++)
      drive((c == 0) ? !idle_lvl() : idle_lvl(),
            (c == d1 || c == d2) ? !idle_lvl() : idle_lvl());
  endtask

  task automatic qualify();
    start_s = 1'b0;
    idle(2);
    frame(8, -1, -1);
    frame(8, -1, -1);
    idle(2);
  endtask

  task automatic measure(input logic fmt, input int len, input int d1, input int d2,
                         input string req);
    int exp;
    fmt_s = fmt;
    qualify();
    start_s = 1'b1;
    idle(2);
    frame(len, d1, d2);
    check({req, "/R8 done before 2nd edge"}, done_w, 0);
    drive(!idle_lvl(), idle_lvl());
    exp = expect_off(len, d1, d2);
    check({req, "/R8 done"}, done_w, 1);
    check(req, offset_w, exp);
    last_off = offset_w;
    idle(2);
    start_s = 1'b0;
    idle(1);
    check("R10 done clears", done_w, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    fmt_s = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 done at reset", done_w, 0);
    check("R1 offset at reset", offset_w, 0);
    rst_n = 1'b1;
    idle(2);
    check("R1 done after reset", done_w, 0);

    measure(1'b0, 40, 13, -1, "R2 falling");
    measure(1'b1, 40, 21, -1, "R3 rising");
    measure(1'b0, 30, 0, -1, "R5 same-cycle");
    measure(1'b1, 30, 0, -1, "R5 same-cycle rising");
    measure(1'b0, 40, 3, 9, "R4 first edge");
    measure(1'b1, 40, 17, 25, "R4 first edge rising");
    measure(1'b0, 40, -1, -1, "R6 no edge");
    measure(1'b1, 4200, 4150, -1, "R7 saturation");

    // R10/R11: start dropped mid-measurement, then an unqualified re-raise
    fmt_s = 1'b0;
    qualify();
    start_s = 1'b1;
    idle(2);
    frame(4, 2, -1);
    start_s = 1'b0;
    idle(1);
    start_s = 1'b1;
    frame(10, 4, -1);
    frame(10, 4, -1);
    frame(10, 4, -1);
    check("R10 aborted no done", done_w, 0);
    check("R11 offset held", offset_w, last_off);

    // R9: low across a single reference edge only
    start_s = 1'b0;
    frame(8, -1, -1);
    idle(2);
    start_s = 1'b1;
    frame(12, 5, -1);
    frame(12, 5, -1);
    idle(1);
    check("R9 unqualified start ignored", done_w, 0);
    check("R9/R11 offset unchanged", offset_w, last_off);
    start_s = 1'b0;
    idle(1);

    // Random mix of formats, frame lengths and edge positions
    for (int n = 0; n < 20; n++) begin
      logic f;
      int len, d1, d2;
      f   = 1'($urandom_range(0, 1));
      len = int'($urandom_range(16, 200));
      d1  = ($urandom_range(0, 5) == 0) ? -1 : int'($urandom_range(0, len - 1));
      d2  = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, len - 1)) : -1;
      measure(f, len, d1, d2, f ? "R3 random" : "R2 random");
    end

    finish_run();
  end
endmodule